// File: doc/BRIEF.md
# Accumulator Status Flag Unit

This block produces and holds the processor status byte for the active 16-bit accumulator. The zero and sign bits are not stored. They are taken directly from the accumulator value that the surrounding datapath supplies, so they change in the same cycle as that value. The overflow, carry and equal bits are stored. They are updated by a small built-in add/subtract core that executes one operation per cycle when `opValid` is high. Two general-purpose bits carry no hardware meaning and hold whatever software last wrote to them.

The integrated core accepts two operands and an operation code. It returns the 16-bit result at once, so that the datapath can write it back to the accumulator. On the next clock edge it records the carry or borrow and the signed overflow. A compare operation records only whether the operands are equal. Software can write the general-purpose, carry and equal bits through a single write strobe. When a write and a hardware update reach the same bit in the same cycle, the hardware value is kept.

Top module: `acc_flag_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, with `accValue` = 0, `status` reads 80h.
- R2: `status[7]` is 1 exactly when `accValue` is zero, in the same cycle, and software cannot write it.
- R3: `status[6]` equals `accValue[15]` in the same cycle, and software cannot write it.
- R4: `status[5]` always reads 0.
- R5: One cycle after an ADD, ADDC, SUB or SUBB, `status[2]` is 1 when the operation overflowed as a signed operation and 0 otherwise. This bit cannot be written by software.
- R6: One cycle after an ADD (opKind 0) or an ADDC (opKind 1), `status[1]` holds the unsigned carry out of `opA + opB + cin`. For ADDC, cin is the current `status[1]`; for ADD it is 0.
- R7: One cycle after a SUB (opKind 2) or a SUBB (opKind 3), `status[1]` is 1 when `opA < opB + bin`, that is, when a borrow occurs. For SUBB, bin is the current `status[1]`; for SUB it is 0.
- R8: One cycle after a CMP (opKind 4), `status[0]` is 1 if `opA == opB` and 0 otherwise. `status[2:1]` is left unchanged.
- R9: One cycle after `swWrEn`, bits 4, 3, 1 and 0 of `status` take the same bits of `swWrData`. The written values of bits 7, 6, 5 and 2 are ignored.
- R10: When an operation and a software write occur in the same cycle, the operation's update of a bit takes precedence over the write. Bits that the operation does not touch take the written value.
- R11: When `opValid` is low, or when `opKind` is 5 to 7, no stored flag changes unless software writes it.
- R12: `opResult` is, without a clock delay, the low 16 bits of `opA + opB + cin` for opKind 0 and 1, and of `opA - opB - bin` for opKind 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValue | input | 16 | Value of the active accumulator |
| opValid | input | 1 | Execute the operation selected by opKind this cycle |
| opKind | input | 3 | 0 ADD, 1 ADDC, 2 SUB, 3 SUBB, 4 CMP, 5-7 no operation |
| opA | input | 16 | First operand (minuend for subtract) |
| opB | input | 16 | Second operand |
| swWrEn | input | 1 | Software write strobe for the status byte |
| swWrData | input | 8 | Software write data |
| opResult | output | 16 | Combinational result of the add/subtract core |
| status | output | 8 | Status byte {Z, S, 0, GP1, GP0, OV, C, E} |

## Verification
A stored carry bit that holds a wrong value does not show up alone. It shows as a wrong `status[1]` one cycle after the fault. The next ADDC or SUBB then adds or subtracts it, so `opResult` is also wrong in that same cycle. For this reason every cycle compares `opResult` and the whole status byte against a reference model that runs alongside the design. A wrong overflow bit or equal bit is visible only at `status[2]` or `status[0]`. It stays visible until the next operation of the matching kind, so the checks cover both the cycle right after each update and the idle cycles that follow it.

// File: rtl/acc_flag_pkg.sv
package acc_flag_pkg;

  localparam int STATUS_W = 8;
  localparam int BIT_ZERO = 7;
  localparam int BIT_SIGN = 6;
  localparam int BIT_RSVD = 5;
  localparam int BIT_GP1  = 4;
  localparam int BIT_GP0  = 3;
  localparam int BIT_OVF  = 2;
  localparam int BIT_CRY  = 1;
  localparam int BIT_EQU  = 0;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_CMP  = 3'd4
  } opKind_e;

  // Strobes sent from the decoder to the flag datapath
  typedef struct packed {
    logic arithEn;   // update carry and overflow
    logic subSel;    // subtract instead of add
    logic useCarry;  // fold the stored carry in as carry-in or borrow-in
    logic cmpEn;     // update the equal flag
    logic swWr;      // software write of the writable bits
  } flagStrobe_t;

endpackage

// File: rtl/acc_flag_ctrl.sv
module acc_flag_ctrl
  import acc_flag_pkg::*;
(
  input  logic        opValid,
  input  logic [2:0]  opKind,
  input  logic        swWrEn,
  output flagStrobe_t strobe
);

  always_comb begin
    strobe      = '0;
    strobe.swWr = swWrEn;
    if (opValid) begin
      case (opKind)
        OP_ADD:  strobe.arithEn = 1'b1;
        OP_ADDC: begin
          strobe.arithEn  = 1'b1;
          strobe.useCarry = 1'b1;
        end
        OP_SUB: begin
          strobe.arithEn = 1'b1;
          strobe.subSel  = 1'b1;
        end
        OP_SUBB: begin
          strobe.arithEn  = 1'b1;
          strobe.subSel   = 1'b1;
          strobe.useCarry = 1'b1;
        end
        OP_CMP:  strobe.cmpEn = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_flag_dp.sv
module acc_flag_dp
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobe_t         strobe,
  input  logic [DATA_W-1:0]   accValue,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [STATUS_W-1:0] swWrData,
  output logic [DATA_W-1:0]   opResult,
  output logic [STATUS_W-1:0] status
);

  localparam int LOW_W = DATA_W - 1;

  logic             carryQ, ovfQ, equQ;
  logic [1:0]       gpQ;
  logic [DATA_W-1:0] bEff;
  logic             cinEff;
  logic [LOW_W-1:0] lowSum;
  logic             carryLow;   // carry out of the next-to-top bit
  logic             topSum;
  logic             carryTop;   // carry out of the top bit
  logic             carryNext;
  logic             ovfNext;

  // subtraction as A + ~B + (1 - borrowIn)
  always_comb begin
    bEff   = strobe.subSel ? ~opB : opB;
    cinEff = strobe.useCarry & carryQ;
    if (strobe.subSel) cinEff = ~cinEff;
  end

  always_comb begin
    {carryLow, lowSum} = {1'b0, opA[LOW_W-1:0]} + {1'b0, bEff[LOW_W-1:0]}
                       + {{LOW_W{1'b0}}, cinEff};
    {carryTop, topSum} = {1'b0, opA[DATA_W-1]} + {1'b0, bEff[DATA_W-1]}
                       + {1'b0, carryLow};
    carryNext = strobe.subSel ? ~carryTop : carryTop;
    ovfNext   = carryLow ^ carryTop;
  end

  assign opResult = {topSum, lowSum};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ <= 1'b0;
      ovfQ   <= 1'b0;
      equQ   <= 1'b0;
      gpQ    <= 2'b00;
    end else begin
      if (strobe.swWr) begin
        gpQ    <= swWrData[BIT_GP1:BIT_GP0];
        carryQ <= swWrData[BIT_CRY];
        equQ   <= swWrData[BIT_EQU];
      end
      // hardware updates come last so they take precedence
      if (strobe.arithEn) begin
        carryQ <= carryNext;
        ovfQ   <= ovfNext;
      end
      if (strobe.cmpEn) equQ <= (opA == opB);
    end
  end

  always_comb begin
    status           = '0;
    status[BIT_ZERO] = ~|accValue;
    status[BIT_SIGN] = accValue[DATA_W-1];
    status[BIT_GP1]  = gpQ[1];
    status[BIT_GP0]  = gpQ[0];
    status[BIT_OVF]  = ovfQ;
    status[BIT_CRY]  = carryQ;
    status[BIT_EQU]  = equQ;
  end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] accValue,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              swWrEn,
  input  logic [7:0]        swWrData,
  output logic [DATA_W-1:0] opResult,
  output logic [7:0]        status
);

  flagStrobe_t strobe;

  acc_flag_ctrl u_ctrl (
    .opValid (opValid),
    .opKind  (opKind),
    .swWrEn  (swWrEn),
    .strobe  (strobe)
  );

  acc_flag_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .accValue (accValue),
    .opA      (opA),
    .opB      (opB),
    .swWrData (swWrData),
    .opResult (opResult),
    .status   (status)
  );

endmodule

// File: rtl/acc_flag_checker.sv
module acc_flag_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] accValue,
  input logic              opValid,
  input logic [2:0]        opKind,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              swWrEn,
  input logic [7:0]        swWrData,
  input logic [DATA_W-1:0] opResult,
  input logic [7:0]        status
);

  a_r2_zero_follows: assert property (@(posedge clk) disable iff (!rstN)
    status[7] == (accValue == '0));

  a_r3_sign_follows: assert property (@(posedge clk) disable iff (!rstN)
    status[6] == accValue[DATA_W-1]);

  a_r4_reserved_low: assert property (@(posedge clk) disable iff (!rstN)
    status[5] == 1'b0);

  a_r5_add_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd0) |=>
      status[2] == $past((opA[DATA_W-1] == opB[DATA_W-1]) &&
                         (opResult[DATA_W-1] != opA[DATA_W-1])));

  a_r8_cmp_equal: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd4) |=> status[0] == $past(opA == opB));

  a_r8_cmp_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == 3'd4 && !swWrEn) |=> $stable(status[2:1]));

  a_r9_sw_write: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && !opValid) |=>
      (status[4:3] == $past(swWrData[4:3])) && (status[1:0] == $past(swWrData[1:0])));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!swWrEn && (!opValid || opKind > 3'd4)) |=> $stable(status[4:0]));

endmodule

bind acc_flag_unit acc_flag_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValue (accValue),
  .opValid  (opValid),
  .opKind   (opKind),
  .opA      (opA),
  .opB      (opB),
  .swWrEn   (swWrEn),
  .swWrData (swWrData),
  .opResult (opResult),
  .status   (status)
);

// File: tb/acc_flag_unit_tb.sv
module acc_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] accValue = '0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = '0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        swWrEn = 1'b0;
  logic [7:0]  swWrData = '0;
  logic [15:0] opResult;
  logic [7:0]  status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic       mC = 1'b0, mOv = 1'b0, mE = 1'b0;
  logic [1:0] mGp = 2'b00;

  always #10 clk = ~clk;  // 50 MHz

  acc_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .accValue(accValue), .opValid(opValid),
    .opKind(opKind), .opA(opA), .opB(opB), .swWrEn(swWrEn),
    .swWrData(swWrData), .opResult(opResult), .status(status)
  );

  function automatic logic [7:0] expStatus(input logic [15:0] acc);
    return {acc == 16'h0, acc[15], 1'b0, mGp, mOv, mC, mE};
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: opResult actual %04h expected %04h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic v, input logic [2:0] k, input logic [15:0] a,
                      input logic [15:0] b, input logic w, input logic [7:0] wd,
                      input logic [15:0] acc, input string tag);
    logic [16:0] full;
    logic        cin, arith, sub;
    logic        nC, nOv;
    opValid = v; opKind = k; opA = a; opB = b;
    swWrEn = w; swWrData = wd; accValue = acc;
    arith = v && (k <= 3'd3);
    sub   = (k == 3'd2) || (k == 3'd3);
    cin   = ((k == 3'd1) || (k == 3'd3)) ? mC : 1'b0;
    if (sub) full = {1'b0, a} - {1'b0, b} - {16'h0, cin};
    else     full = {1'b0, a} + {1'b0, b} + {16'h0, cin};
    if (sub) nOv = (a[15] != b[15]) && (full[15] != a[15]);
    else     nOv = (a[15] == b[15]) && (full[15] != a[15]);
    nC = full[16];
    #1;
    if (arith) check16({tag, " R12"}, opResult, full[15:0]);
    if (w) begin
      mGp = wd[4:3]; mC = wd[1]; mE = wd[0];
    end
    if (arith) begin
      mC = nC; mOv = nOv;
    end
    if (v && k == 3'd4) mE = (a == b);
    @(negedge clk);
    check8(tag, status, expStatus(acc));
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check8("R1 during reset", status, 8'h80);
    rstN = 1'b1;
    @(negedge clk);
    check8("R1 after reset", status, 8'h80);

    // R2 / R3 zero and sign, no operation
    step(0, 3'd0, 16'h0, 16'h0, 0, 8'h00, 16'h8001, "R3 sign set");
    step(0, 3'd0, 16'h0, 16'h0, 0, 8'h00, 16'h0000, "R2 zero set");
    // R9 write all ones: only 4,3,1,0 stick; R4 bit 5 stays 0
    step(0, 3'd0, 16'h0, 16'h0, 1, 8'hFF, 16'h0123, "R9 R4 write ones");
    check8("R9 value", status, 8'h1B);
    step(0, 3'd0, 16'h0, 16'h0, 1, 8'h00, 16'h0000, "R9 R2 write zeros");
    // R5 signed overflow on add
    step(1, 3'd0, 16'h7FFF, 16'h0001, 0, 8'h00, 16'h1, "R5 add overflow");
    // R6 unsigned carry on add
    step(1, 3'd0, 16'hFFFF, 16'h0001, 0, 8'h00, 16'h1, "R6 add carry");
    // R6 ADDC uses carry=1
    step(1, 3'd1, 16'h0000, 16'h0000, 0, 8'h00, 16'h1, "R6 addc carry in");
    // R7 borrow
    step(1, 3'd2, 16'h0000, 16'h0001, 0, 8'h00, 16'h1, "R7 sub borrow");
    step(1, 3'd3, 16'h0005, 16'h0005, 0, 8'h00, 16'h1, "R7 subb borrow in");
    step(1, 3'd2, 16'h8000, 16'h0001, 0, 8'h00, 16'h1, "R5 sub overflow");
    // R8 compare keeps C and OV
    step(1, 3'd4, 16'h1234, 16'h1234, 0, 8'h00, 16'h1, "R8 cmp equal");
    step(1, 3'd4, 16'h1234, 16'h1235, 0, 8'h00, 16'h1, "R8 cmp differ");
    // R10 hardware beats write on carry; GP bits and E from the write
    step(1, 3'd0, 16'h0001, 16'h0001, 1, 8'h1B, 16'h1, "R10 add vs write");
    step(1, 3'd4, 16'h0007, 16'h0007, 1, 8'h02, 16'h1, "R10 cmp vs write");
    // R11 reserved op codes and idle
    step(1, 3'd6, 16'hFFFF, 16'hFFFF, 0, 8'h00, 16'h1, "R11 reserved op");
    step(0, 3'd2, 16'h0000, 16'h0001, 0, 8'h00, 16'h1, "R11 invalid op");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] acc;
      logic [15:0] a, b;
      acc = ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom);
      a = 16'($urandom);
      b = ($urandom_range(0, 5) == 0) ? a : 16'($urandom);
      step($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), a, b,
           $urandom_range(0, 4) == 0, 8'($urandom), acc, "R2-random R5 R6 R7 R8 R10 R11");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule